// File: doc/BRIEF.md
# Modulo 65537 Multiplier

This unit multiplies two 16-bit words in the ring of integers modulo 2^16+1. The all-zero word is not a true zero here. It encodes the value 65536, so every one of the 65536 input codes names a nonzero residue. This is the multiplication step that block ciphers built on that group use. The unit does not use a general divider. It forms the 32-bit product and folds it back: the high half is subtracted from the low half, and the difference gets one added to it when the subtraction borrows. An operand equal to zero takes a short path that returns one minus the other operand.

A parameter selects between two forms. In the registered form (the default), the operands are captured when `in_valid` is high, and the result comes out one clock later along with `out_valid`. In the combinational form, the result and `in_valid` pass straight through.

Top module: `mm_mul65537`

## Requirements
- R1: When `op_a` is 0 and `op_b` is nonzero, the result is (1 - `op_b`) truncated to 16 bits.
- R2: When `op_b` is 0 and `op_a` is nonzero, the result is (1 - `op_a`) truncated to 16 bits.
- R3: When both operands are 0, the result is 1, because 65536 squared is 1 modulo 65537.
- R4: When both operands are nonzero, the result equals the operand product modulo 65537, with the residue 65536 encoded as 0. Examples: 0x8000 times 2 gives 0, and 0xFFFF times 0xFFFF gives 4.
- R5: An operand equal to 1 is the identity: the result equals the other operand.
- R6: In registered mode, `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. The result belongs to the operands presented in that earlier cycle.
- R7: After a synchronous reset (active-high `rst`), `out_valid` is 0 and `result` is 0.
- R8: In registered mode, a cycle with `in_valid` low leaves `result` unchanged, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 16 | First operand (0 means 65536) |
| op_b | input | 16 | Second operand (0 means 65536) |
| out_valid | output | 1 | Result is valid |
| result | output | 16 | Product modulo 65537 (0 means 65536) |

## Verification
Every cycle, the assertions check the one-cycle valid timing, the holding of the result when no operands arrive, and the closed-form results of the zero and identity operands. Only the bench's scenarios can confirm that the general fold is correct. They compare values against a golden model that computes the product modulo 65537 directly. This covers the borrow edge, the case where the residue is 65536, and a long run of pseudo-random operand pairs.

// File: rtl/mm_pkg.sv
package mm_pkg;
    parameter int unsigned MM_W = 16;
    localparam int unsigned MM_PW = 2 * MM_W;

    typedef logic [MM_W-1:0]  mm_word_t;
    typedef logic [MM_PW-1:0] mm_prod_t;

    typedef enum logic [1:0] {
        MM_GENERAL = 2'd0,
        MM_A_ZERO  = 2'd1,
        MM_B_ZERO  = 2'd2
    } mm_case_e;

    typedef struct packed {
        mm_word_t a;
        mm_word_t b;
    } mm_pair_t;

    typedef struct packed {
        logic     borrow;
        mm_word_t diff;
    } mm_fold_t;

    // Residue for "zero stands for 2^W" operand: 2^W * x == -x, so 1 - x after the wrap
    function automatic mm_word_t mm_one_minus(mm_word_t x);
        return mm_word_t'(1) - x;
    endfunction
endpackage

// File: rtl/mm_classify.sv
module mm_classify
    import mm_pkg::*;
(
    input  mm_pair_t pair,
    output mm_case_e kind
);
    always_comb begin
        if (pair.a == '0)
            kind = MM_A_ZERO;   // also covers both-zero: 1 - 0 = 1
        else if (pair.b == '0)
            kind = MM_B_ZERO;
        else
            kind = MM_GENERAL;
    end
endmodule

// File: rtl/mm_fold.sv
module mm_fold
    import mm_pkg::*;
(
    input  mm_pair_t pair,
    output mm_word_t folded
);
    mm_prod_t prod;
    mm_word_t lo_half;
    mm_word_t hi_half;
    mm_fold_t sub;

    always_comb begin
        prod    = mm_prod_t'(pair.a) * mm_prod_t'(pair.b);
        lo_half = prod[MM_W-1:0];
        hi_half = prod[MM_PW-1:MM_W];
        // 2^W == -1, so hi*2^W + lo == lo - hi; a borrow means +2^W was added, fix with +1
        sub     = {1'b0, lo_half} - {1'b0, hi_half};
        folded  = sub.diff + mm_word_t'(sub.borrow);
    end
endmodule

// File: rtl/mm_select.sv
module mm_select
    import mm_pkg::*;
(
    input  mm_case_e kind,
    input  mm_pair_t pair,
    input  mm_word_t folded,
    output mm_word_t res
);
    always_comb begin
        unique case (kind)
            MM_A_ZERO: res = mm_one_minus(pair.b);
            MM_B_ZERO: res = mm_one_minus(pair.a);
            default:   res = folded;
        endcase
    end
endmodule

// File: rtl/mm_mul65537.sv
module mm_mul65537
    import mm_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  mm_word_t op_a,
    input  mm_word_t op_b,
    output logic     out_valid,
    output mm_word_t result
);
    mm_pair_t pair;
    mm_case_e kind;
    mm_word_t folded;
    mm_word_t next_res;

    assign pair = '{a: op_a, b: op_b};

    mm_classify u_classify (.pair(pair), .kind(kind));
    mm_fold     u_fold     (.pair(pair), .folded(folded));
    mm_select   u_select   (.kind(kind), .pair(pair), .folded(folded), .res(next_res));

    generate
        if (REGISTERED) begin : g_reg
            logic     valid_q;
            mm_word_t res_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q <= 1'b0;
                    res_q   <= '0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid)
                        res_q <= next_res;
                end
            end

            assign out_valid = valid_q;
            assign result    = res_q;

            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);                                          // R6
            AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);                                        // R6
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(result));                                   // R8
            AST_A_ZERO_PATH: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_a == '0 && op_b != '0)
                |=> result == mm_word_t'(mm_word_t'(1) - $past(op_b)));         // R1
            AST_B_ZERO_PATH: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_b == '0 && op_a != '0)
                |=> result == mm_word_t'(mm_word_t'(1) - $past(op_a)));         // R2
            AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_a == '0 && op_b == '0) |=> result == mm_word_t'(1)); // R3
            AST_IDENTITY: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_a == mm_word_t'(1)) |=> result == $past(op_b));  // R5
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = next_res;
        end
    endgenerate
endmodule

// File: tb/tb_mm_mul65537.sv
`timescale 1ns/1ps
module tb_mm_mul65537;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] op_a, op_b;
    logic        out_valid;
    logic [15:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    mm_mul65537 dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result)
    );

    // a, b, expected (hand-worked residues)
    localparam int NV = 14;
    localparam logic [47:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 16'h0001},   // R3
        {16'h0000, 16'h0001, 16'h0000},   // R1
        {16'h0001, 16'h0000, 16'h0000},   // R2
        {16'h0000, 16'h0002, 16'hFFFF},   // R1
        {16'h0000, 16'hFFFF, 16'h0002},   // R1
        {16'hFFFF, 16'h0000, 16'h0002},   // R2
        {16'h0001, 16'h04D2, 16'h04D2},   // R5
        {16'h1234, 16'h0001, 16'h1234},   // R5
        {16'h0002, 16'h0003, 16'h0006},   // R4
        {16'hFFFF, 16'hFFFF, 16'h0004},   // R4
        {16'hFFFF, 16'h0002, 16'hFFFD},   // R4
        {16'h8000, 16'h0002, 16'h0000},   // R4 residue 65536
        {16'h0100, 16'h0100, 16'h0000},   // R4 residue 65536
        {16'h0200, 16'h0100, 16'hFFFF}    // R4 borrow
    };

    function automatic logic [15:0] golden(logic [15:0] a, logic [15:0] b);
        longint av, bv, p;
        av = (a == 16'h0) ? 64'd65536 : longint'(a);
        bv = (b == 16'h0) ? 64'd65536 : longint'(b);
        p  = (av * bv) % 65537;
        return p[15:0];
    endfunction

    function automatic string req_of(logic [15:0] a, logic [15:0] b);
        if (a == 0 && b == 0) return "R3";
        if (a == 0) return "R1";
        if (b == 0) return "R2";
        if (a == 1 || b == 1) return "R5";
        return "R4";
    endfunction

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one operand pair, then sample one cycle later away from the edge
    task automatic apply(logic [15:0] a, logic [15:0] b, logic [15:0] exp, string req);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check16(req, result, exp);
        check16("R6", {15'd0, out_valid}, 16'd1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [15:0] held;
        rst = 1'b1; in_valid = 1'b0; op_a = 16'h0; op_b = 16'h0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check16("R7", {15'd0, out_valid}, 16'd0);
        check16("R7", result, 16'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], req_of(VEC[i][47:32], VEC[i][31:16]));
            check16("R4 golden", result, golden(VEC[i][47:32], VEC[i][31:16]));
        end

        // R6: out_valid drops in the cycle after in_valid falls
        @(negedge clk);
        check16("R6", {15'd0, out_valid}, 16'd0);

        // R8: idle cycle with new operands leaves result unchanged
        apply(16'h0003, 16'h0005, 16'h000F, "R4");
        held = result;
        @(negedge clk);
        in_valid = 1'b0; op_a = 16'h7777; op_b = 16'h0000;
        @(negedge clk);
        check16("R8", result, held);
        check16("R6", {15'd0, out_valid}, 16'd0);

        // R6: back-to-back operands, each result one cycle after its input
        @(negedge clk);
        in_valid = 1'b1; op_a = 16'h0000; op_b = 16'h0003;
        @(negedge clk);
        check16("R1", result, 16'hFFFE);
        op_a = 16'h0007; op_b = 16'h0000;
        @(negedge clk);
        check16("R2", result, 16'hFFFA);
        check16("R6", {15'd0, out_valid}, 16'd1);
        in_valid = 1'b0;

        // R4: pseudo-random sweep against the golden model
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a, b;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            a = lfsr[15:0];
            b = lfsr[31:16];
            if (i % 37 == 0) a = 16'h0;
            if (i % 41 == 0) b = 16'h0;
            apply(a, b, golden(a, b), req_of(a, b));
        end

        // R7: reset mid-stream clears state
        @(negedge clk);
        in_valid = 1'b1; op_a = 16'h0002; op_b = 16'h0002;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check16("R7", {15'd0, out_valid}, 16'd0);
        check16("R7", result, 16'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule